// File: doc/BRIEF.md
# Instruction Fetch Lane Selector

This unit sits between an instruction-fetch front end and a memory port that is 64 bits wide. It takes a 32-bit virtual fetch address and a size flag (halfword or word). First it tests the address for alignment. It then converts the address to a physical one using fixed segment windows. It sends one read request to memory, flipping the low physical address bits when reverse-endian mode is on. From the returned doubleword it picks the instruction out of the correct byte lane, and the lane depends on whether the CPU runs big-endian.

A fetch that fails the alignment test never reaches memory. It finishes one cycle after acceptance with the exception flag set and a zero instruction. The unit works on one fetch at a time. It accepts a request only when idle, and it reports each result as a single-cycle pulse.

Top module: `ifetch_lane_unit`

## Requirements
- R1: A word fetch whose address has bits [1:0] other than 00 is misaligned, and so is a halfword fetch whose address has bit 0 set. A misaligned fetch issues no memory request. In the cycle after acceptance it shows res_valid=1, res_exc=1 and res_instr=0.
- R2: A virtual address in 0x80000000..0x9FFFFFFF becomes the physical address vaddr-0x80000000.
- R3: A virtual address in 0xA0000000..0xBFFFFFFF becomes the physical address vaddr-0xA0000000.
- R4: Any other virtual address is used unchanged as the physical address.
- R5: mem_req_addr is the physical byte address. When rev_endian is 1, its bits [2:0] are XORed with 3'b100 for a word fetch or 3'b110 for a halfword fetch. Bits [31:3] are never altered.
- R6: The byte lane is vaddr[2:0], XORed with 3'b100 (word) or 3'b110 (halfword) when big_endian is 1. res_instr holds the response data shifted right by 8*lane bits. It keeps 32 bits for a word fetch, or the low 16 bits zero-extended for a halfword fetch.
- R7: req_ready is 1 only while idle. mem_req_valid stays at 1, with mem_req_addr stable, until mem_req_ready is seen.
- R8: For an aligned fetch, res_valid pulses for exactly one cycle, in the cycle after mem_rsp_valid is seen, with res_exc=0. Every result pulse lasts one cycle.
- R9: rev_endian and big_endian are sampled only when the request is accepted. Later changes do not affect that fetch's address or instruction.
- R10: After reset, req_ready=1, mem_req_valid=0 and res_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual fetch address |
| req_half | input | 1 | 1 = halfword fetch, 0 = word fetch |
| rev_endian | input | 1 | Reverse-endian addressing mode |
| big_endian | input | 1 | Big-endian CPU lane selection |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Adjusted physical byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned doubleword |
| res_valid | output | 1 | Result pulse |
| res_instr | output | 32 | Fetched instruction |
| res_exc | output | 1 | Instruction-fetch alignment exception |

## Verification
The assertions take three things for granted about the inputs. Memory returns mem_rsp_valid only after it has taken the request, and never while a request is still pending. A response arrives only for a request the unit actually issued. Nothing beyond those is assumed. The bench keeps to these rules by driving the response strictly after the mem_req_ready handshake, one fetch at a time. It also flips both mode inputs while a fetch is in flight, which exercises R9 without breaking any input rule.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/ifl_addr_map.sv
module ifl_addr_map #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 3,
  parameter int unsigned INSTR_W = 32,
  parameter logic [ADDR_W-1:0] SEG0_LO = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] SEG1_LO = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] SEG_HI  = 32'hC000_0000
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              half,
  input  logic              rev,
  input  logic              big,
  output logic              misalign,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [OFF_W-1:0]  lane
);
  localparam logic [OFF_W-1:0] OFF_MASK  = OFF_W'((1 << OFF_W) - 1);
  localparam logic [OFF_W-1:0] WORD_CODE = OFF_W'(INSTR_W / 8 - 1);
  localparam logic [OFF_W-1:0] HALF_CODE = OFF_W'(INSTR_W / 16 - 1);

  function automatic logic [ADDR_W-1:0] seg_translate(input logic [ADDR_W-1:0] va);
    if (va >= SEG0_LO && va < SEG1_LO)      return va - SEG0_LO;
    else if (va >= SEG1_LO && va < SEG_HI) return va - SEG1_LO;
    else                                    return va;
  endfunction

  function automatic logic [OFF_W-1:0] flip_bits(input logic [OFF_W-1:0] code);
    return OFF_MASK ^ code;
  endfunction

  logic [OFF_W-1:0]  code;
  logic [OFF_W-1:0]  flip;
  logic [ADDR_W-1:0] paddr;

  always_comb begin
    code     = half ? HALF_CODE : WORD_CODE;
    flip     = flip_bits(code);
    misalign = |(vaddr[OFF_W-1:0] & code);
    paddr    = seg_translate(vaddr);
    mem_addr = {paddr[ADDR_W-1:OFF_W], paddr[OFF_W-1:0] ^ (rev ? flip : '0)};
    lane     = vaddr[OFF_W-1:0] ^ (big ? flip : '0);
  end
endmodule

// File: rtl/ifl_lane_extract.sv
module ifl_lane_extract #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OFF_W   = 3
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [OFF_W-1:0]   lane,
  input  logic               half,
  output logic [INSTR_W-1:0] instr
);
  localparam int unsigned NLANE = DATA_W / 8;
  localparam int unsigned HW    = INSTR_W / 2;
  localparam int unsigned PAD_W = DATA_W + INSTR_W - 8;

  logic [PAD_W-1:0]   padded;
  logic [INSTR_W-1:0] cand [NLANE];
  logic [INSTR_W-1:0] word;

  assign padded = {{(INSTR_W-8){1'b0}}, data};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign cand[g] = padded[8*g +: INSTR_W];
  end

  always_comb begin
    word  = cand[lane];
    instr = half ? {{(INSTR_W-HW){1'b0}}, word[HW-1:0]} : word;
  end
endmodule

// File: rtl/ifl_fsm.sv
module ifl_fsm
  import ifl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         misalign,
  input  logic         mem_req_ready,
  input  logic         mem_rsp_valid,
  output fetch_state_e state,
  output logic         rsp_fire
);
  fetch_state_e nxt;

  assign rsp_fire = (state == ST_WAIT) && mem_rsp_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (accept) nxt = misalign ? ST_DONE : ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) nxt = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ifetch_lane_unit.sv
module ifetch_lane_unit
  import ifl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_half,
  input  logic               rev_endian,
  input  logic               big_endian,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               res_valid,
  output logic [INSTR_W-1:0] res_instr,
  output logic               res_exc
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);

  fetch_state_e       state;
  logic               accept_fire;
  logic               misalign_c;
  logic               rsp_fire;
  logic [ADDR_W-1:0]  addr_c;
  logic [OFF_W-1:0]   lane_c;
  logic [INSTR_W-1:0] instr_c;

  logic [ADDR_W-1:0]  addr_q;
  logic [OFF_W-1:0]   lane_q;
  logic               half_q;
  logic [INSTR_W-1:0] instr_q;
  logic               exc_q;

  assign req_ready   = (state == ST_IDLE);
  assign accept_fire = req_valid && req_ready;

  ifl_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INSTR_W(INSTR_W)) u_map (
    .vaddr    (req_vaddr),
    .half     (req_half),
    .rev      (rev_endian),
    .big      (big_endian),
    .misalign (misalign_c),
    .mem_addr (addr_c),
    .lane     (lane_c)
  );

  ifl_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept_fire),
    .misalign      (misalign_c),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state),
    .rsp_fire      (rsp_fire)
  );

  ifl_lane_extract #(.DATA_W(DATA_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W)) u_ext (
    .data  (mem_rsp_data),
    .lane  (lane_q),
    .half  (half_q),
    .instr (instr_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lane_q  <= '0;
      half_q  <= 1'b0;
      instr_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      if (accept_fire) begin
        addr_q <= addr_c;
        lane_q <= lane_c;
        half_q <= req_half;
        if (misalign_c) begin
          instr_q <= '0;
          exc_q   <= 1'b1;
        end
      end
      if (rsp_fire) begin
        instr_q <= instr_c;
        exc_q   <= 1'b0;
      end
    end
  end

  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (state == ST_DONE);
  assign res_instr     = instr_q;
  assign res_exc       = exc_q;
endmodule

// File: rtl/ifl_checker.sv
module ifl_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned INSTR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               res_valid,
  input logic               res_exc,
  input logic [INSTR_W-1:0] res_instr,
  input logic               accept_fire,
  input logic               misalign_c,
  input logic               rsp_fire
);
  // R1: misaligned fetch completes next cycle with exception and zero data
  a_r1_exc_result: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire && misalign_c |=> res_valid && res_exc && (res_instr == '0));

  // R1: misaligned fetch never drives a memory request
  a_r1_no_mem_req: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire && misalign_c |=> !mem_req_valid);

  // R7: request held with stable address until taken
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7: ready only while nothing is in flight
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !res_valid);

  // R8: result is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8: response leads to a clean result the next cycle
  a_r8_rsp_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> res_valid && !res_exc);
endmodule

bind ifetch_lane_unit ifl_checker #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_exc       (res_exc),
  .res_instr     (res_instr),
  .accept_fire   (accept_fire),
  .misalign_c    (misalign_c),
  .rsp_fire      (rsp_fire)
);

// File: tb/ifetch_lane_unit_tb_top.sv
module ifetch_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_half = 1'b0;
  logic        rev_endian = 1'b0;
  logic        big_endian = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_instr;
  logic        res_exc;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        exc;
    logic [31:0] instr;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  ifetch_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_half(req_half), .rev_endian(rev_endian), .big_endian(big_endian),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
    .res_instr(res_instr), .res_exc(res_exc)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_paddr(input logic [31:0] va);
    case (va[31:29])
      3'b100:  return {3'b000, va[28:0]};   // R2
      3'b101:  return {3'b000, va[28:0]};   // R3
      default: return va;                   // R4
    endcase
  endfunction

  function automatic logic [31:0] model_instr(input logic [63:0] d, input logic [2:0] l, input bit h);
    logic [7:0] b [0:10];
    for (int i = 0; i < 8; i++) b[i] = d[8*i +: 8];
    for (int i = 8; i < 11; i++) b[i] = 8'h00;
    if (h) return {16'h0000, b[l+1], b[l]};
    return {b[l+3], b[l+2], b[l+1], b[l]};
  endfunction

  task automatic do_fetch(input logic [31:0] va, input bit h, input bit rev, input bit big,
                          input logic [63:0] data, input string tag);
    exp_t e;
    bit mis;
    logic [2:0] flip;
    logic [31:0] exp_addr;
    logic [2:0] lane;
    mis  = h ? va[0] : (va[1:0] != 2'b00);
    flip = h ? 3'b110 : 3'b100;
    exp_addr = model_paddr(va);
    if (rev) exp_addr[2:0] = exp_addr[2:0] ^ flip;
    lane = big ? (va[2:0] ^ flip) : va[2:0];
    e.exc = mis;
    e.instr = mis ? 32'h0 : model_instr(data, lane, h);
    e.tag = tag;
    while (!req_ready) @(negedge clk);
    sb_q.push_back(e);
    req_valid = 1'b1; req_vaddr = va; req_half = h; rev_endian = rev; big_endian = big;
    @(negedge clk);
    req_valid = 1'b0;
    rev_endian = ~rev; big_endian = ~big;   // R9: flipped after acceptance
    check(!req_ready, "R7 ready low while busy", 64'(req_ready), 64'd0);
    if (mis) begin
      check(!mem_req_valid, "R1 no memory request", 64'(mem_req_valid), 64'd0);
    end else begin
      while (!mem_req_valid) @(negedge clk);
      check(mem_req_addr == exp_addr, {tag, " R5/R9 mem address"}, 64'(mem_req_addr), 64'(exp_addr));
      @(negedge clk);
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == exp_addr, "R7 request held stable",
            64'(mem_req_addr), 64'(exp_addr));
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      @(negedge clk);
      mem_rsp_data = data; mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare each result pulse against the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", 64'(res_instr), 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(res_exc == e.exc, {e.tag, " R1/R8 exception flag"}, 64'(res_exc), 64'(e.exc));
          check(res_instr == e.instr, {e.tag, " R6/R9 instruction"}, 64'(res_instr), 64'(e.instr));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req_valid && !res_valid, "R10 reset state",
          {61'd0, req_ready, mem_req_valid, res_valid}, 64'h4);

    do_fetch(32'h8000_1000, 1'b0, 1'b0, 1'b0, 64'h8877_6655_4433_2211, "R2 word le");
    do_fetch(32'h8000_1004, 1'b0, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, "R6 word big");
    do_fetch(32'hA000_2006, 1'b1, 1'b0, 1'b0, 64'hFEDC_BA98_7654_3210, "R3 half lane6");
    do_fetch(32'hA000_2002, 1'b1, 1'b1, 1'b1, 64'h1122_3344_5566_7788, "R5 half rev big");
    do_fetch(32'h0040_0004, 1'b0, 1'b1, 1'b0, 64'hCAFE_F00D_DEAD_BEEF, "R4 word rev");
    do_fetch(32'h9FFF_FFFC, 1'b0, 1'b0, 1'b0, 64'hA1A2_A3A4_B1B2_B3B4, "R2 upper edge");
    do_fetch(32'hBFFF_FFFE, 1'b1, 1'b0, 1'b0, 64'h5A5B_5C5D_5E5F_6061, "R3 upper edge");
    do_fetch(32'hC000_0000, 1'b0, 1'b1, 1'b1, 64'h1357_9BDF_2468_ACE0, "R4 above segments");
    do_fetch(32'h7FFF_FFF8, 1'b1, 1'b1, 1'b0, 64'h0F1E_2D3C_4B5A_6978, "R4 below segments");
    do_fetch(32'hA000_0000, 1'b1, 1'b0, 1'b1, 64'h9988_7766_5544_3322, "R3 lower edge");
    do_fetch(32'h8000_0002, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 word misaligned");
    do_fetch(32'h8000_0001, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R1 half misaligned");
    do_fetch(32'h0000_0003, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R1 word odd");
    do_fetch(32'h0000_0002, 1'b1, 1'b0, 1'b0, 64'h7766_5544_3322_1100, "R1 half aligned ok");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule